// File: doc/BRIEF.md
# Channel-List ADC Acquisition Controller

This block connects a 16-bit register bus to a 12-bit multi-channel analog-to-digital converter. The host loads a short list of conversion entries, picks how conversions are triggered and enables the list and the sample buffer. Each trigger takes the current list entry and drives its channel, gain, polarity and reference selects to the analog side. It then starts the converter, waits for the converter's ready strobe and stores the result in a sample FIFO in offset binary form.

The host reads the FIFO and a status word through the same bus. A read of offset 0x00 is itself a trigger source in software mode, and a read of offset 0x10 pops one sample. An interrupt output can flag that the FIFO has reached half its depth. The list pointer wraps to the first entry after the last loaded one, so repeated triggers cycle through the list.

Top module: `adc_list_ctrl`

## Requirements
- R1: While a conversion runs, `cv_chan`, `cv_gain`, `cv_unipolar` and `cv_diff` carry bits 3:0, 5:4, 6 and 7 of the current list entry and stay stable until the conversion completes.
- R2: A write to offset 0x00 sets the trigger mode from bits 1:0 (0 off, 1 software, 2 scan, 3 external). In software mode a bus read of offset 0x00 starts exactly one conversion. In mode 0 no conversion starts.
- R3: In scan mode a rising edge of `scan_trig` starts a conversion. In external mode an edge of `ext_trig` starts one: the rising edge when bit 3 of the offset 0x00 register is 0, the falling edge when it is 1.
- R4: Each sample is stored as the converter's two's-complement result XOR 0x800. Bus reads of offset 0x10 return the samples in conversion order in bits 11:0.
- R5: After each completed conversion the list pointer advances. After the last loaded entry it returns to entry 0.
- R6: A write of an entry (bits 7:0) to offset 0x10 appends it to the list. When the list already holds 16 entries the write is ignored. Status bit 1 reports a full list.
- R7: The status word at offset 0x04 reports FIFO full in bit 4, half-full (at least 512 samples) in bit 3, empty in bit 2 and a running conversion in bit 0.
- R8: A read of offset 0x10 while the FIFO is empty returns the previously read sample and does not change the FIFO state.
- R9: Bit 10 of the offset 0x02 register enables the FIFO and bit 9 enables the list. While either bit is clear, its storage is flushed and no trigger starts a conversion. List writes are ignored while bit 9 is clear.
- R10: With bit 8 of the offset 0x00 register set, the FIFO reaching half-full sets pending status bit 8. `irq` is high while a half-full interrupt is pending and bit 15 is set. Any write to offset 0x04 clears the pending flag.
- R11: `cv_start` is a one-cycle pulse. A trigger that arrives while a conversion runs is ignored.
- R12: A sample that completes while the FIFO holds 1024 samples is dropped, and the stored samples are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Half-full interrupt request |
| scan_trig | input | 1 | Scan trigger input (rising edge) |
| ext_trig | input | 1 | External trigger input (selectable edge) |
| cv_start | output | 1 | Start pulse to the converter |
| cv_chan | output | 4 | Multiplexer channel select |
| cv_gain | output | 2 | Gain code |
| cv_unipolar | output | 1 | Unipolar input range select |
| cv_diff | output | 1 | Differential reference select |
| cv_ready | input | 1 | Converter result strobe |
| cv_data | input | 12 | Converter result, two's complement |

## Verification
The converter model returns a value built from the selects it sees on the analog outputs, so each stored sample shows whether the right list entry reached the pins and whether the offset-binary flip was applied. A four-entry list is run through eight software triggers: entries that differ in every field tell field swaps apart, and the second pass through the list shows whether the pointer wraps. Each of the other trigger modes gets one edge in each direction, which separates rising-edge from falling-edge detection. A single-entry list is then run until the FIFO passes its half-full and full boundaries, and every sample is read back. An overflow that corrupts the count shows up in the empty flag at the end.

// File: rtl/adc_list_pkg.sv
package adc_list_pkg;
  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_SW   = 2'd1,
    TRIG_SCAN = 2'd2,
    TRIG_EXT  = 2'd3
  } trig_mode_t;

  localparam logic [5:0] OFS_CTRL1 = 6'h00;
  localparam logic [5:0] OFS_CTRL2 = 6'h02;
  localparam logic [5:0] OFS_STAT  = 6'h04;
  localparam logic [5:0] OFS_LIST  = 6'h10;
endpackage

// File: rtl/adc_chan_list.sv
module adc_chan_list
  import adc_list_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  list_entry_t                wr_entry,
  input  logic                       adv,
  output list_entry_t                cur_entry,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  list_entry_t     mem [DEPTH];
  logic [PW-1:0]   ptr;

  assign full      = (cnt == CW'(DEPTH));
  assign cur_entry = mem[ptr];

  always_ff @(posedge clk) begin
    if (wr_en && !full && !clr) mem[cnt[PW-1:0]] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ptr <= '0;
    end else begin
      if (wr_en && !full) cnt <= cnt + 1'b1;
      if (adv) begin
        if (cnt == '0 || {1'b0, ptr} == cnt - 1'b1) ptr <= '0;
        else ptr <= ptr + 1'b1;
      end
    end
  end

  AST_LIST_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !clr) |=> $stable(cnt)); // R6
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> ({1'b0, ptr} < cnt)); // R5
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (do_pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> $stable(count)); // R12
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> ($stable(dout) && empty)); // R8
endmodule

// File: rtl/adc_list_ctrl.sv
module adc_list_ctrl
  import adc_list_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int FIFO_DEPTH = 1024,
  parameter int SAMPLE_W   = 12,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              scan_trig,
  input  logic              ext_trig,
  output logic              cv_start,
  output logic [3:0]        cv_chan,
  output logic [1:0]        cv_gain,
  output logic              cv_unipolar,
  output logic              cv_diff,
  input  logic              cv_ready,
  input  logic [SAMPLE_W-1:0] cv_data
);
  localparam int LCW = $clog2(LIST_DEPTH+1);
  localparam int FCW = $clog2(FIFO_DEPTH+1);
  localparam logic [SAMPLE_W-1:0] SIGN_FLIP = SAMPLE_W'(1) << (SAMPLE_W-1);
  localparam logic [FCW-1:0]      HALF_MARK = FCW'(FIFO_DEPTH/2);

  // control state
  trig_mode_t trig_mode;
  logic fall_edge, hf_irq_en, irq_glb_en, fifo_en, list_en;
  logic scan_q, ext_q, busy, hf_pend, half_q, rd_fifo_q;
  logic [DATA_W-1:0] rdata_q;

  logic rd, wr, trig, go, adv, pop, list_wr;
  logic scan_rise, ext_edge, half, clr_stat;
  list_entry_t         cur_entry;
  logic [LCW-1:0]      list_cnt;
  logic                list_full;
  logic [SAMPLE_W-1:0] fifo_dout;
  logic [FCW-1:0]      fifo_cnt;
  logic                fifo_full, fifo_empty;
  logic [DATA_W-1:0]   status;

  assign rd       = bus_sel && !bus_wr;
  assign wr       = bus_sel && bus_wr;
  assign pop      = rd && (bus_addr == OFS_LIST);
  assign list_wr  = wr && (bus_addr == OFS_LIST) && list_en;
  assign clr_stat = wr && (bus_addr == OFS_STAT);

  assign scan_rise = scan_trig && !scan_q;
  assign ext_edge  = fall_edge ? (!ext_trig && ext_q) : (ext_trig && !ext_q);

  always_comb begin
    unique case (trig_mode)
      TRIG_SW:   trig = rd && (bus_addr == OFS_CTRL1);
      TRIG_SCAN: trig = scan_rise;
      TRIG_EXT:  trig = ext_edge;
      default:   trig = 1'b0;
    endcase
  end

  assign go   = trig && !busy && fifo_en && list_en && (list_cnt != '0);
  assign adv  = busy && cv_ready;
  assign half = (fifo_cnt >= HALF_MARK);

  adc_chan_list #(.DEPTH(LIST_DEPTH)) i_list (
    .clk(clk), .rst(rst), .clr(!list_en),
    .wr_en(list_wr), .wr_entry(list_entry_t'(bus_wdata[7:0])),
    .adv(adv), .cur_entry(cur_entry), .cnt(list_cnt), .full(list_full)
  );

  adc_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .clr(!fifo_en),
    .push(adv), .din(cv_data ^ SIGN_FLIP),
    .pop(pop), .dout(fifo_dout), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty)
  );

  always_comb begin
    status     = '0;
    status[8]  = hf_pend;
    status[4]  = fifo_full;
    status[3]  = half;
    status[2]  = fifo_empty;
    status[1]  = list_full;
    status[0]  = busy;
  end

  // registers written by the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_mode  <= TRIG_OFF;
      fall_edge  <= 1'b0;
      hf_irq_en  <= 1'b0;
      irq_glb_en <= 1'b0;
      fifo_en    <= 1'b0;
      list_en    <= 1'b0;
    end else if (wr) begin
      if (bus_addr == OFS_CTRL1) begin
        trig_mode  <= trig_mode_t'(bus_wdata[1:0]);
        fall_edge  <= bus_wdata[3];
        hf_irq_en  <= bus_wdata[8];
        irq_glb_en <= bus_wdata[15];
      end
      if (bus_addr == OFS_CTRL2) begin
        fifo_en <= bus_wdata[10];
        list_en <= bus_wdata[9];
      end
    end
  end

  // conversion sequencing and analog selects
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q      <= 1'b0;
      ext_q       <= 1'b0;
      busy        <= 1'b0;
      cv_start    <= 1'b0;
      cv_chan     <= '0;
      cv_gain     <= '0;
      cv_unipolar <= 1'b0;
      cv_diff     <= 1'b0;
    end else begin
      scan_q   <= scan_trig;
      ext_q    <= ext_trig;
      cv_start <= go;
      if (go) begin
        busy        <= 1'b1;
        cv_chan     <= cur_entry.chan;
        cv_gain     <= cur_entry.gain;
        cv_unipolar <= cur_entry.unipolar;
        cv_diff     <= cur_entry.diff;
      end else if (adv) begin
        busy <= 1'b0;
      end
    end
  end

  // interrupt and read port
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q    <= 1'b0;
      hf_pend   <= 1'b0;
      irq       <= 1'b0;
      rdata_q   <= '0;
      rd_fifo_q <= 1'b0;
    end else begin
      half_q <= half;
      if (clr_stat) hf_pend <= 1'b0;
      else if (half && !half_q && hf_irq_en) hf_pend <= 1'b1;
      irq <= hf_pend && irq_glb_en;
      if (rd) begin
        rd_fifo_q <= (bus_addr == OFS_LIST);
        rdata_q   <= (bus_addr == OFS_STAT) ? status : '0;
      end
    end
  end

  assign bus_rdata = rd_fifo_q ? {{(DATA_W-SAMPLE_W){1'b0}}, fifo_dout} : rdata_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    cv_start |=> !cv_start); // R11
  AST_SELECTS_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !cv_start) |-> ($stable(cv_chan) && $stable(cv_gain) &&
                             $stable(cv_unipolar) && $stable(cv_diff))); // R1
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_stat |=> !hf_pend); // R10
  AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == TRIG_OFF && !busy) |=> !busy); // R2
endmodule

// File: tb/test_adc_list_ctrl.sv
`timescale 1ns/1ps
module test_adc_list_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, scan_trig = 1'b0, ext_trig = 1'b0;
  logic        cv_start, cv_unipolar, cv_diff;
  logic [3:0]  cv_chan;
  logic [1:0]  cv_gain;
  logic        cv_ready = 1'b0;
  logic [11:0] cv_data = '0;

  int n_checks = 0, n_fail = 0;
  int conv_delay = 2;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  adc_list_ctrl i_adc_list_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .scan_trig(scan_trig), .ext_trig(ext_trig),
    .cv_start(cv_start), .cv_chan(cv_chan), .cv_gain(cv_gain),
    .cv_unipolar(cv_unipolar), .cv_diff(cv_diff),
    .cv_ready(cv_ready), .cv_data(cv_data)
  );

  // entry in bits 19:12, expected stored sample in bits 11:0
  localparam logic [19:0] VEC [4] = '{
    {8'h03, 12'h835}, {8'hB7, 12'h375}, {8'h4C, 12'hCC5}, {8'h21, 12'hA15}
  };

  // converter model: result = {entry seen on the selects, 4'h5}
  initial begin
    logic [7:0] ent;
    forever begin
      @(negedge clk);
      if (cv_start) begin
        ent = {cv_diff, cv_unipolar, cv_gain, cv_chan};
        repeat (conv_delay) @(negedge clk);
        cv_data  = {ent, 4'h5};
        cv_ready = 1'b1;
        @(negedge clk);
        cv_ready = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic convert();
    logic [15:0] dummy;
    bus_read(6'h00, dummy);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, R7
    bus_read(6'h04, rv);
    check("R7 reset status", rv, 16'h0004);
    check("R10 reset irq", {15'd0, irq}, 16'd0);
    check("R11 reset start", {15'd0, cv_start}, 16'd0);

    // enable, software mode, load table entries
    bus_write(6'h02, 16'h0600);
    bus_write(6'h00, 16'h0001);
    for (int i = 0; i < 4; i++) bus_write(6'h10, {8'h00, VEC[i][19:12]});
    // table walk: two passes show wrap (R5), samples show R1, R2, R4
    for (int i = 0; i < 8; i++) begin
      convert();
      bus_read(6'h10, rv);
      check("R1 R4 R5 table sample", rv, {4'h0, VEC[i % 4][11:0]});
    end

    // mode 0: no conversion, R2
    bus_write(6'h00, 16'h0000);
    convert();
    bus_read(6'h04, rv);
    check("R2 mode off no sample", rv, 16'h0004);

    // scan mode, R3
    bus_write(6'h00, 16'h0002);
    @(negedge clk) scan_trig = 1'b1;
    @(negedge clk) scan_trig = 1'b0;
    repeat (6) @(negedge clk);
    bus_read(6'h10, rv);
    check("R3 scan rising", rv, {4'h0, VEC[0][11:0]});

    // external rising
    bus_write(6'h00, 16'h0003);
    @(negedge clk) ext_trig = 1'b1;
    repeat (6) @(negedge clk);
    bus_read(6'h10, rv);
    check("R3 ext rising", rv, {4'h0, VEC[1][11:0]});
    @(negedge clk) ext_trig = 1'b0;
    repeat (6) @(negedge clk);
    bus_read(6'h04, rv);
    check("R3 ext falling ignored in rising mode", rv, 16'h0004);

    // external falling
    bus_write(6'h00, 16'h000B);
    @(negedge clk) ext_trig = 1'b1;
    repeat (6) @(negedge clk);
    bus_read(6'h04, rv);
    check("R3 ext rising ignored in falling mode", rv, 16'h0004);
    @(negedge clk) ext_trig = 1'b0;
    repeat (6) @(negedge clk);
    bus_read(6'h10, rv);
    check("R3 ext falling", rv, {4'h0, VEC[2][11:0]});

    // empty read returns last, R8
    bus_read(6'h10, rv);
    check("R8 empty read value", rv, {4'h0, VEC[2][11:0]});
    bus_read(6'h04, rv);
    check("R8 empty read state", rv, 16'h0004);

    // trigger while busy, R11
    bus_write(6'h00, 16'h0001);
    conv_delay = 10;
    convert();
    convert();
    repeat (10) @(negedge clk);
    conv_delay = 2;
    bus_read(6'h10, rv);
    check("R11 single sample", rv, {4'h0, VEC[3][11:0]});
    bus_read(6'h04, rv);
    check("R11 only one sample", rv, 16'h0004);
    convert();
    bus_read(6'h10, rv);
    check("R11 pointer advanced once", rv, {4'h0, VEC[0][11:0]});

    // list full, R6
    bus_write(6'h02, 16'h0400);
    bus_write(6'h02, 16'h0600);
    for (int i = 0; i < 16; i++) bus_write(6'h10, 16'(i));
    bus_write(6'h10, 16'h00FF);
    bus_read(6'h04, rv);
    check("R6 list full flag", rv, 16'h0006);
    for (int i = 0; i < 17; i++) begin
      convert();
      bus_read(6'h10, rv);
    end
    check("R6 extra write ignored", rv, 16'h0805);

    // flush, R9
    convert();
    convert();
    bus_write(6'h02, 16'h0200);
    bus_read(6'h04, rv);
    check("R9 fifo flushed", rv, 16'h0006);
    convert();
    bus_read(6'h04, rv);
    check("R9 no start with fifo off", rv, 16'h0006);
    bus_write(6'h02, 16'h0400);
    bus_write(6'h10, 16'h0011);
    bus_write(6'h02, 16'h0600);
    convert();
    bus_read(6'h04, rv);
    check("R9 list flushed and write ignored", rv, 16'h0004);

    // half-full irq and full, R7 R10 R12
    bus_write(6'h10, 16'h0011);
    bus_write(6'h00, 16'h8101);
    for (int i = 0; i < 511; i++) convert();
    bus_read(6'h04, rv);
    check("R7 below half", rv, 16'h0000);
    check("R10 no irq below half", {15'd0, irq}, 16'd0);
    convert();
    bus_read(6'h04, rv);
    check("R7 R10 half and pending", rv, 16'h0108);
    check("R10 irq raised", {15'd0, irq}, 16'd1);
    bus_write(6'h04, 16'h0000);
    repeat (2) @(negedge clk);
    check("R10 irq cleared", {15'd0, irq}, 16'd0);
    bus_read(6'h04, rv);
    check("R10 pending cleared", rv, 16'h0008);
    for (int i = 0; i < 512; i++) convert();
    bus_read(6'h04, rv);
    check("R7 full", rv, 16'h0018);
    convert();
    bus_read(6'h04, rv);
    check("R12 still full after extra", rv, 16'h0018);
    for (int i = 0; i < 1024; i++) bus_read(6'h10, rv);
    check("R12 last sample", rv, 16'h0915);
    bus_read(6'h04, rv);
    check("R12 empty after draining", rv, 16'h0004);

    finish_run();
  end
endmodule